// File: doc/BRIEF.md
# Software Inter-Hart Interrupt Controller

This block lets up to eight harts raise software interrupts on one another through a small register map. The layout follows the usual platform interrupt controller: pending bits, per-source priority, per-target enable words, a threshold and a claim/complete register. Every source is a sender/receiver pair. Source N stands for sender N/8 raising target N%8. A hart interrupts a peer by writing a one into its own 8-bit slice of the pending array. The target takes the interrupt by reading its claim register and ends it by writing the source number back.

Each hart has one interrupt line. The line rises one clock after an eligible source appears. A source is eligible when it is pending, enabled, not in service, and its priority is above the target's threshold. Every register access takes one clock on a plain 32-bit port. Read data is combinational during the access cycle, and side effects take place at the closing clock edge.

Top module: `ipi_swctl`

## Requirements
- R1: The pending array sits at 0x1000 and is write-1-to-set, so zero bits leave pending state as it was. Source N maps to word N/32 and to bit N%32 of that word. Sender S owns bits (S%4)×8..+7 of word S/4, and bit T of that slice targets hart T.
- R2: Source 0 is fixed at zero. Its pending bit can never be set and its priority reads 0, whatever is written.
- R3: The priority of source N is at byte offset 4×N and holds 3 bits. It reads back as written, zero-extended.
- R4: Context C has two enable words, at 0x2000 + 0x80×C and 4 bytes above that. Bit B of word W enables source 32×W + B. Context C only considers sources whose target (N%8) is C.
- R5: A read of the claim register of context C (0x200000 + 0x1000×C + 4) returns a candidate source of C and clears that source's pending bit. A candidate is enabled, pending, not in service and has a priority above 0. The winner has the highest priority, and equal priorities go to the lowest ID. The read returns 0 when there is no candidate.
- R6: A claimed source stays in service and is not offered again until it is completed. A complete is a write of its ID to the claim register of its own target context. A complete naming a source that is not in service, or written through another context, is ignored.
- R7: The threshold of context C is at 0x200000 + 0x1000×C. Output bit C is high one clock after a candidate of C has a priority strictly above that threshold, and low one clock after none has.
- R8: Reads of unmapped or unaligned offsets return 0, and writes to them change nothing.
- R9: Reset clears all pending, in-service, priority, enable and threshold state, and drives every interrupt output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid while a read is presented |
| sw_irq | output | 8 | Software interrupt line per hart |

## Verification
The bench sets every bit of the low pending word at once. It then checks that bit 0 stays clear, because a design that stored it would let hart 0 interrupt itself. It arranges priority ties and priority-0 sources: a wrong tie-break returns the higher ID first, and a missing priority-0 filter returns sources that should never fire. It re-pends a source while it is in service, and it completes that source through the wrong context. A design that dropped the in-service hold would hand the same source out twice. Finally it moves the threshold to exactly the source priority and then one below it, where an off-by-one comparison raises or holds the line at the wrong setting.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int REGION_W   = 8;
  localparam int BUS_W      = 32;
  localparam int PEND_BASE  = 32'h0000_1000;
  localparam int EN_BASE    = 32'h0000_2000;
  localparam int EN_STRIDE  = 32'h0000_0080;
  localparam int CTX_BASE   = 32'h0020_0000;
  localparam int CTX_STRIDE = 32'h0000_1000;
  localparam int CLAIM_OFS  = 4;

  typedef enum logic [2:0] {
    K_NONE, K_PRIO, K_PEND, K_EN, K_THR, K_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NUM_HARTS = 8,
  parameter int ADDR_W    = 22,
  parameter int NSRC      = NUM_HARTS * REGION_W,
  parameter int WORDS     = (NSRC + BUS_W - 1) / BUS_W,
  parameter int SRC_W     = $clog2(NSRC),
  parameter int CTX_W     = $clog2(NUM_HARTS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [SRC_W-1:0]  idx,
  output logic [CTX_W-1:0]  ctx
);
  logic [31:0] a32;
  logic [31:0] off;

  always_comb begin
    a32  = 32'(addr);
    off  = '0;
    kind = K_NONE;
    idx  = '0;
    ctx  = '0;
    if (a32[1:0] == 2'b00) begin
      if (a32 < 32'(4 * NSRC)) begin
        kind = K_PRIO;
        idx  = SRC_W'(a32 >> 2);
      end else if (a32 >= PEND_BASE && a32 < PEND_BASE + 4 * WORDS) begin
        off  = a32 - PEND_BASE;
        kind = K_PEND;
        idx  = SRC_W'(off >> 2);
      end else if (a32 >= EN_BASE && a32 < EN_BASE + EN_STRIDE * NUM_HARTS) begin
        off = a32 - EN_BASE;
        if ((off % EN_STRIDE) < 32'(4 * WORDS)) begin
          kind = K_EN;
          ctx  = CTX_W'(off / EN_STRIDE);
          idx  = SRC_W'((off % EN_STRIDE) >> 2);
        end
      end else if (a32 >= CTX_BASE && a32 < CTX_BASE + CTX_STRIDE * NUM_HARTS) begin
        off = a32 - CTX_BASE;
        ctx = CTX_W'(off / CTX_STRIDE);
        if ((off % CTX_STRIDE) == 0)              kind = K_THR;
        else if ((off % CTX_STRIDE) == CLAIM_OFS) kind = K_CLAIM;
      end
    end
  end
endmodule

// File: rtl/ipi_src_bank.sv
module ipi_src_bank
  import ipi_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 3,
  parameter int WORDS  = (NSRC + BUS_W - 1) / BUS_W,
  parameter int SRC_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_we,
  input  logic [SRC_W-1:0]  pend_word,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              prio_we,
  input  logic [SRC_W-1:0]  prio_idx,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              claim_fire,
  input  logic [SRC_W-1:0]  claim_id,
  input  logic              cmp_fire,
  input  logic [SRC_W-1:0]  cmp_id,
  output logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   insvc,
  output logic [PRIO_W-1:0] prio [NSRC]
);
  logic [NSRC-1:0] pend_d, insvc_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_zero
      assign pend_d[i]  = 1'b0;
      assign insvc_d[i] = 1'b0;
      assign prio[i]    = '0;
    end else begin : g_live
      logic              set_b, clr_b;
      logic              prio_en;
      logic [PRIO_W-1:0] prio_q;
      assign set_b   = pend_we && (32'(pend_word) == i / BUS_W) && wdata[i % BUS_W];
      assign clr_b   = claim_fire && (32'(claim_id) == i);
      assign pend_d[i]  = (pend[i] | set_b) & ~clr_b;
      assign insvc_d[i] = (insvc[i] | clr_b) &
                          ~(cmp_fire && (32'(cmp_id) == i));
      assign prio_en = prio_we && (32'(prio_idx) == i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prio_q <= '0;
        else if (prio_en) prio_q <= prio_wdata;
      end
      assign prio[i] = prio_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      insvc <= '0;
    end else begin
      pend  <= pend_d;
      insvc <= insvc_d;
    end
  end
endmodule

// File: rtl/ipi_arbiter.sv
module ipi_arbiter
  import ipi_pkg::*;
#(
  parameter int NUM_HARTS = 8,
  parameter int CTX       = 0,
  parameter int PRIO_W    = 3,
  parameter int NSRC      = NUM_HARTS * REGION_W,
  parameter int SRC_W     = $clog2(NSRC)
) (
  input  logic [NUM_HARTS-1:0] pend,
  input  logic [NUM_HARTS-1:0] insvc,
  input  logic [NUM_HARTS-1:0] en,
  input  logic [PRIO_W-1:0]    prio [NUM_HARTS],
  input  logic [PRIO_W-1:0]    thr,
  output logic [SRC_W-1:0]     best_id,
  output logic                 irq_req
);
  logic [PRIO_W-1:0] best_prio;

  // Sender index s gives source s*REGION_W + CTX; descending scan with >=
  // lets the lower ID win a tie.
  always_comb begin
    best_prio = '0;
    best_id   = '0;
    for (int s = NUM_HARTS - 1; s >= 0; s--) begin
      if (pend[s] && en[s] && !insvc[s] && prio[s] != '0 && prio[s] >= best_prio) begin
        best_prio = prio[s];
        best_id   = SRC_W'(s * REGION_W + CTX);
      end
    end
    irq_req = best_prio > thr;
  end
endmodule

// File: rtl/ipi_swctl.sv
module ipi_swctl
  import ipi_pkg::*;
#(
  parameter int NUM_HARTS = 8,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] sw_irq
);
  localparam int NSRC  = NUM_HARTS * REGION_W;
  localparam int WORDS = (NSRC + BUS_W - 1) / BUS_W;
  localparam int SRC_W = $clog2(NSRC);
  localparam int CTX_W = $clog2(NUM_HARTS);
  localparam int EN_W  = WORDS * BUS_W;

  reg_kind_e         dec_kind;
  logic [SRC_W-1:0]  dec_idx;
  logic [CTX_W-1:0]  dec_ctx;
  logic              wr_cyc, rd_cyc;
  logic              claim_fire, cmp_wr, cmp_fire;
  logic [SRC_W-1:0]  claim_id, cmp_id;
  logic [NSRC-1:0]   pend_vec, insvc_vec;
  logic [PRIO_W-1:0] prio_arr [NSRC];
  logic [EN_W-1:0]   en_q [NUM_HARTS];
  logic [EN_W-1:0]   en_d [NUM_HARTS];
  logic [PRIO_W-1:0] thr_q [NUM_HARTS];
  logic [PRIO_W-1:0] thr_d [NUM_HARTS];
  logic [SRC_W-1:0]  best_id [NUM_HARTS];
  logic [NUM_HARTS-1:0] irq_req, irq_q;
  logic [EN_W-1:0]   pend_pad;

  ipi_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .kind(dec_kind), .idx(dec_idx), .ctx(dec_ctx)
  );

  assign wr_cyc     = req_valid && req_write;
  assign rd_cyc     = req_valid && !req_write;
  assign claim_id   = best_id[dec_ctx];
  assign claim_fire = rd_cyc && dec_kind == K_CLAIM && claim_id != '0;
  assign cmp_wr     = wr_cyc && dec_kind == K_CLAIM;
  assign cmp_id     = req_wdata[SRC_W-1:0];
  assign cmp_fire   = cmp_wr && (req_wdata >> SRC_W) == '0 && insvc_vec[cmp_id] &&
                      (32'(cmp_id) % REGION_W) == 32'(dec_ctx);

  ipi_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .pend_we(wr_cyc && dec_kind == K_PEND), .pend_word(dec_idx), .wdata(req_wdata),
    .prio_we(wr_cyc && dec_kind == K_PRIO), .prio_idx(dec_idx),
    .prio_wdata(req_wdata[PRIO_W-1:0]),
    .claim_fire(claim_fire), .claim_id(claim_id),
    .cmp_fire(cmp_fire), .cmp_id(cmp_id),
    .pend(pend_vec), .insvc(insvc_vec), .prio(prio_arr)
  );

  for (genvar c = 0; c < NUM_HARTS; c++) begin : g_ctx
    logic [NUM_HARTS-1:0] sl_pend, sl_svc, sl_en;
    logic [PRIO_W-1:0]    sl_prio [NUM_HARTS];
    for (genvar s = 0; s < NUM_HARTS; s++) begin : g_slice
      assign sl_pend[s] = pend_vec[s * REGION_W + c];
      assign sl_svc[s]  = insvc_vec[s * REGION_W + c];
      assign sl_en[s]   = en_q[c][s * REGION_W + c];
      assign sl_prio[s] = prio_arr[s * REGION_W + c];
    end

    ipi_arbiter #(.NUM_HARTS(NUM_HARTS), .CTX(c), .PRIO_W(PRIO_W)) u_arb (
      .pend(sl_pend), .insvc(sl_svc), .en(sl_en), .prio(sl_prio),
      .thr(thr_q[c]), .best_id(best_id[c]), .irq_req(irq_req[c])
    );

    always_comb begin
      en_d[c]  = en_q[c];
      thr_d[c] = thr_q[c];
      if (wr_cyc && 32'(dec_ctx) == c) begin
        if (dec_kind == K_EN)  en_d[c][32'(dec_idx) * BUS_W +: BUS_W] = req_wdata;
        if (dec_kind == K_THR) thr_d[c] = req_wdata[PRIO_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end else begin
        en_q[c]  <= en_d[c];
        thr_q[c] <= thr_d[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_req;
  end
  assign sw_irq = irq_q;

  always_comb begin
    pend_pad  = '0;
    pend_pad[NSRC-1:0] = pend_vec;
    rsp_rdata = '0;
    if (rd_cyc) begin
      unique case (dec_kind)
        K_PRIO:  rsp_rdata = 32'(prio_arr[dec_idx]);
        K_PEND:  rsp_rdata = pend_pad[32'(dec_idx) * BUS_W +: BUS_W];
        K_EN:    rsp_rdata = en_q[dec_ctx][32'(dec_idx) * BUS_W +: BUS_W];
        K_THR:   rsp_rdata = 32'(thr_q[dec_ctx]);
        K_CLAIM: rsp_rdata = 32'(claim_id);
        default: rsp_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_swctl_chk.sv
module ipi_swctl_chk
  import ipi_pkg::*;
#(
  parameter int NSRC  = 64,
  parameter int SRC_W = 6,
  parameter int CTX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [31:0]      rsp_rdata,
  input reg_kind_e        kind,
  input logic [CTX_W-1:0] ctx,
  input logic             claim_fire,
  input logic [SRC_W-1:0] claim_id,
  input logic             cmp_wr,
  input logic [SRC_W-1:0] cmp_id,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  insvc
);
  // R2
  pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !pend[0]);

  // R5
  claim_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> !pend[$past(claim_id)]);

  // R5
  claim_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |-> (32'(claim_id) % REGION_W) == 32'(ctx));

  // R6
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> insvc[$past(claim_id)]);

  // R6
  bad_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !insvc[cmp_id]) |=> $stable(insvc));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && kind == K_NONE) |-> rsp_rdata == 32'h0);
endmodule

bind ipi_swctl ipi_swctl_chk #(.NSRC(NSRC), .SRC_W(SRC_W), .CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_rdata(rsp_rdata), .kind(dec_kind), .ctx(dec_ctx),
  .claim_fire(claim_fire), .claim_id(claim_id),
  .cmp_wr(cmp_wr), .cmp_id(cmp_id), .pend(pend_vec), .insvc(insvc_vec)
);

// File: tb/test_ipi_swctl.sv
`timescale 1ns/1ps
module test_ipi_swctl;
  typedef struct packed {
    logic        wr;
    logic [21:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 22'h000000, 32'h0,        32'h0,        4'd2}, // R2 src0 prio
    '{1'b1, 22'h000004, 32'h5,        32'h0,        4'd3}, // R3
    '{1'b0, 22'h000004, 32'h0,        32'h5,        4'd3}, // R3 readback
    '{1'b1, 22'h000000, 32'h7,        32'h0,        4'd2},
    '{1'b0, 22'h000000, 32'h0,        32'h0,        4'd2}, // R2 prio stays 0
    '{1'b1, 22'h001000, 32'hFFFFFFFF, 32'h0,        4'd1}, // R1
    '{1'b0, 22'h001000, 32'h0,        32'hFFFFFFFE, 4'd2}, // R2 bit0 clear
    '{1'b1, 22'h001000, 32'h0,        32'h0,        4'd1},
    '{1'b0, 22'h001000, 32'h0,        32'hFFFFFFFE, 4'd1}, // R1 zeros no effect
    '{1'b0, 22'h001004, 32'h0,        32'h0,        4'd1}, // R1 word1 untouched
    '{1'b1, 22'h002000, 32'h01010101, 32'h0,        4'd4}, // R4
    '{1'b0, 22'h002000, 32'h0,        32'h01010101, 4'd4},
    '{1'b0, 22'h200004, 32'h0,        32'h0,        4'd5}, // R5 prio 0 never wins
    '{1'b1, 22'h000020, 32'h2,        32'h0,        4'd3},
    '{1'b1, 22'h000060, 32'h2,        32'h0,        4'd3},
    '{1'b0, 22'h200004, 32'h0,        32'd8,        4'd5}, // R5 tie lowest id
    '{1'b0, 22'h200004, 32'h0,        32'd24,       4'd5},
    '{1'b0, 22'h200004, 32'h0,        32'h0,        4'd5},
    '{1'b0, 22'h001000, 32'h0,        32'hFEFFFEFE, 4'd5}, // R5 claim clears
    '{1'b1, 22'h001000, 32'h00000100, 32'h0,        4'd6},
    '{1'b0, 22'h200004, 32'h0,        32'h0,        4'd6}, // R6 in service
    '{1'b1, 22'h200004, 32'd24,       32'h0,        4'd6},
    '{1'b0, 22'h200004, 32'h0,        32'h0,        4'd6},
    '{1'b1, 22'h200004, 32'd8,        32'h0,        4'd6},
    '{1'b0, 22'h200004, 32'h0,        32'd8,        4'd6}, // R6 after complete
    '{1'b1, 22'h002080, 32'h02020202, 32'h0,        4'd4},
    '{1'b1, 22'h000024, 32'h7,        32'h0,        4'd3},
    '{1'b0, 22'h201004, 32'h0,        32'd9,        4'd5}, // R5 higher prio
    '{1'b0, 22'h201004, 32'h0,        32'd1,        4'd5},
    '{1'b0, 22'h003000, 32'h0,        32'h0,        4'd8}, // R8 unmapped
    '{1'b0, 22'h201004, 32'h0,        32'h0,        4'd5},
    '{1'b1, 22'h201004, 32'd8,        32'h0,        4'd6}, // R6 wrong context
    '{1'b1, 22'h001000, 32'h00000100, 32'h0,        4'd6},
    '{1'b0, 22'h200004, 32'h0,        32'h0,        4'd6}  // R6 still held
  };

  logic        clk, rst_n, req_valid, req_write;
  logic [21:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic [7:0]  sw_irq;
  int          n_chk, n_bad;

  ipi_swctl i_ipi_swctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .sw_irq(sw_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [21:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1 rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic run();
    logic [31:0] rd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    check("R9 irq after reset", 32'(sw_irq), 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].wr, VEC[v].addr, VEC[v].data, rd);
      if (!VEC[v].wr) check($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].exp);
    end

    // R7 threshold boundary on context 2, source 34 (sender 4 -> hart 2)
    access(1'b1, 22'h002104, 32'h04040404, rd);
    access(1'b1, 22'h000088, 32'h3, rd);
    access(1'b1, 22'h202000, 32'h3, rd);
    access(1'b1, 22'h001004, 32'h4, rd);
    idle();
    check("R7 prio equal to threshold", 32'(sw_irq), 32'h0);
    access(1'b1, 22'h202000, 32'h2, rd);
    idle();
    check("R7 prio above threshold", 32'(sw_irq), 32'h04);
    access(1'b0, 22'h202004, 32'h0, rd);
    check("R5 claim ctx2", rd, 32'd34);
    idle();
    check("R6 irq drops in service", 32'(sw_irq), 32'h0);
    access(1'b1, 22'h001004, 32'h4, rd);
    idle();
    check("R6 re-pend held", 32'(sw_irq), 32'h0);
    access(1'b1, 22'h202004, 32'd34, rd);
    idle();
    check("R6 complete re-arms", 32'(sw_irq), 32'h04);
    // R8 write past the pending array
    access(1'b1, 22'h001008, 32'hFFFFFFFF, rd);
    access(1'b0, 22'h001004, 32'h0, rd);
    check("R8 unmapped write ignored", rd, 32'h4);
    access(1'b1, 22'h001006, 32'hFFFFFFFF, rd);
    access(1'b0, 22'h001004, 32'h0, rd);
    check("R8 unaligned write ignored", rd, 32'h4);
    access(1'b0, 22'h202000, 32'h0, rd);
    check("R7 threshold readback", rd, 32'h2);

    // R9 reset in mid-run
    access(1'b1, 22'h001004, 32'hFF, rd);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R9 irq low in reset", 32'(sw_irq), 32'h0);
    access(1'b0, 22'h001004, 32'h0, rd);
    check("R9 pending cleared", rd, 32'h0);
    access(1'b0, 22'h000004, 32'h0, rd);
    check("R9 priority cleared", rd, 32'h0);
    access(1'b0, 22'h002000, 32'h0, rd);
    check("R9 enable cleared", rd, 32'h0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule